// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the data transfers of a single DMA channel. A configuration load places a start address, a transfer count, a page value and the channel mode into both a base copy and a working copy. Each time the channel's request is present, the channel is unmasked and the bus grant is given, one transfer is performed in that same cycle. During that cycle the block drives the full memory address and a write or read strobe. At the following clock edge it advances the working address and count.

The count is programmed as the number of transfers minus one. The transfer that finds the count at zero is the last one, and the block flags it as terminal count. After terminal count the channel does one of two things. If auto-initialise is selected, the working registers are reloaded from the base copy and the channel stays open. Otherwise the channel masks itself. A parameter selects byte mode or 16-bit word mode. In word mode the address and count are in word units, the working address is shifted left by one under the page, and page bit 0 is not used. A residue output gives the remaining transfers, in bytes.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the channel is masked, the working address and count are zero, no transfer or strobe is active, and the mode is verify, non-cascade, without auto-initialise.
- R2: `xfer` is high in exactly the cycles where `dreq` and `grant` are high, `masked` is low and cascade mode is off.
- R3: After each transfer that is not a terminal-count reload and has no load in the same cycle, the address goes up by one (wrapping within the address counter, page unchanged) and the count goes down by one.
- R4: A channel loaded with count N-1 performs exactly N transfers. `tc` is high on the transfer that starts with the count at zero, and only on a transfer.
- R5: With auto-initialise set, terminal count reloads the working address and count from the base copy, and the channel stays unmasked.
- R6: Without auto-initialise, terminal count sets `masked` at the next edge. Requests are then ignored until `msk_clr` is applied. Setting the mask (by `msk_set` or by terminal count) wins over `msk_clr` in the same cycle.
- R7: The direction code is 2'b01 for a write to memory (`mem_wr` during a transfer) and 2'b10 for a read from memory (`mem_rd` during a transfer). Codes 2'b00 (verify) and 2'b11 pulse neither strobe. At most one strobe is high at a time.
- R8: In cascade mode the channel performs no transfer and no strobe. `casc_req` follows `dreq` while the channel is unmasked.
- R9: In byte mode `mem_addr` is the page value above the 16-bit working address.
- R10: In word mode `mem_addr` is page bits [7:1] above the working address shifted left by one. Page bit 0 has no effect and `mem_addr` bit 0 is always zero.
- R11: `residue` equals the working count plus one in byte mode, and twice that value in word mode (0xFFFF gives 0x10000 and 0x20000).
- R12: A load takes priority over a transfer in the same cycle, so the loaded address and count are what follows. A load does not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld | input | 1 | Load base and working registers, page and mode |
| ld_addr | input | 16 | Start address (words in word mode) |
| ld_cnt | input | 16 | Transfer count minus one |
| ld_page | input | 8 | Page value for the upper address bits |
| ld_auto | input | 1 | Auto-initialise on terminal count |
| ld_dir | input | 2 | Direction code (01 write to memory, 10 read from memory) |
| ld_casc | input | 1 | Cascade mode |
| msk_set | input | 1 | Set the channel mask |
| msk_clr | input | 1 | Clear the channel mask |
| dreq | input | 1 | Channel request |
| grant | input | 1 | Bus grant for this cycle |
| xfer | output | 1 | A transfer takes place this cycle |
| tc | output | 1 | This transfer is the last of the block |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 24 | Memory byte address |
| casc_req | output | 1 | Request passed through in cascade mode |
| masked | output | 1 | Channel mask state |
| residue | output | 18 | Remaining transfers, in bytes |

## Verification
The most delicate case is the last transfer of a block. Terminal count, the auto-initialise reload (or the self-mask) and sometimes a new load or a mask clear all act at the same edge. The bench provokes this with directed loads of small counts, a load placed on the terminal-count cycle and a mask clear on the same edge as terminal count. Random traffic with short counts adds more of these collisions. After each edge a bench model built from the requirements predicts which action wins, and the registered address, count, residue and mask are compared in the following cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    DIR_VERIFY   = 2'b00,
    DIR_TO_MEM   = 2'b01,
    DIR_FROM_MEM = 2'b10,
    DIR_RSVD     = 2'b11
  } dir_e;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [ADDR_W-1:0]    ld_addr,
  input  logic [CNT_W-1:0]     ld_cnt,
  input  logic [PAGE_W-1:0]    ld_page,
  input  logic                 ld_auto,
  input  dma_seq_pkg::dir_e    ld_dir,
  input  logic                 ld_casc,
  input  logic                 step,
  output logic [ADDR_W-1:0]    cur_addr,
  output logic [CNT_W-1:0]     cur_cnt,
  output logic [PAGE_W-1:0]    page,
  output logic                 auto_en,
  output dma_seq_pkg::dir_e    dir,
  output logic                 casc,
  output logic                 cnt_zero
);
  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_cnt;
  logic              reload_ev;
  logic              adv_ev;

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  assign cnt_zero  = (cur_cnt == '0);
  assign reload_ev = step && cnt_zero && auto_en;
  assign adv_ev    = step && !reload_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      page      <= '0;
      auto_en   <= 1'b0;
      dir       <= dma_seq_pkg::DIR_VERIFY;
      casc      <= 1'b0;
    end else if (ld) begin
      base_addr <= ld_addr;
      base_cnt  <= ld_cnt;
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_cnt;
      page      <= ld_page;
      auto_en   <= ld_auto;
      dir       <= ld_dir;
      casc      <= ld_casc;
    end else if (reload_ev) begin
      cur_addr  <= base_addr;
      cur_cnt   <= base_cnt;
    end else if (adv_ev) begin
      cur_addr  <= addr_next(cur_addr);
      cur_cnt   <= cnt_next(cur_cnt);
    end
  end

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev && !ld |=> cur_addr == ADDR_W'($past(cur_addr) + ADDR_W'(1)));
  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev && !ld |=> cur_cnt == CNT_W'($past(cur_cnt) - CNT_W'(1)));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev && !ld |=> cur_cnt == base_cnt && cur_addr == base_addr);
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cur_cnt == $past(ld_cnt) && cur_addr == $past(ld_addr));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dreq,
  input  logic              grant,
  input  logic              msk_set,
  input  logic              msk_clr,
  input  logic              cnt_zero,
  input  logic              auto_en,
  input  dma_seq_pkg::dir_e dir,
  input  logic              casc,
  output logic              xfer,
  output logic              tc,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              casc_req,
  output logic              masked
);
  logic open_ev;
  logic self_mask_ev;

  assign open_ev      = dreq && !masked;
  assign xfer         = open_ev && grant && !casc;
  assign casc_req     = open_ev && casc;
  assign tc           = xfer && cnt_zero;
  assign self_mask_ev = tc && !auto_en;
  assign mem_wr       = xfer && (dir == dma_seq_pkg::DIR_TO_MEM);
  assign mem_rd       = xfer && (dir == dma_seq_pkg::DIR_FROM_MEM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       masked <= 1'b1;
    else if (msk_set || self_mask_ev) masked <= 1'b1;
    else if (msk_clr)                 masked <= 1'b0;
  end

  a_r6_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
    tc && !auto_en |=> masked);
  a_r5_auto_open: assert property (@(posedge clk) disable iff (!rst_n)
    tc && auto_en && !msk_set |=> !masked);
  a_r2_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !xfer && !casc_req);
  a_r4_tc_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> xfer);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd}));
  a_r8_casc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    casc |-> !xfer && !mem_wr && !mem_rd);
endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0,
  localparam int MA_W     = PAGE_W + ADDR_W,
  localparam int RES_W    = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [PAGE_W-1:0] page,
  output logic [MA_W-1:0]   mem_addr,
  output logic [RES_W-1:0]  residue
);
  function automatic logic [CNT_W:0] left_of(input logic [CNT_W-1:0] c);
    return {1'b0, c} + (CNT_W+1)'(1);
  endfunction

  logic [CNT_W:0] remain;
  assign remain = left_of(cur_cnt);

  generate
    if (WORD_MODE) begin : g_word
      logic unused_pg0;
      assign unused_pg0 = page[0];
      assign mem_addr   = {page[PAGE_W-1:1], cur_addr, 1'b0};
      assign residue    = {remain, 1'b0};
      a_r10_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[0] == 1'b0);
    end else begin : g_byte
      assign mem_addr = {page, cur_addr};
      assign residue  = {1'b0, remain};
    end
  endgenerate

  a_r11_residue_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    residue != '0);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_MODE = 1'b0,
  localparam int MA_W     = PAGE_W + ADDR_W,
  localparam int RES_W    = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic              ld_auto,
  input  logic [1:0]        ld_dir,
  input  logic              ld_casc,
  input  logic              msk_set,
  input  logic              msk_clr,
  input  logic              dreq,
  input  logic              grant,
  output logic              xfer,
  output logic              tc,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [MA_W-1:0]   mem_addr,
  output logic              casc_req,
  output logic              masked,
  output logic [RES_W-1:0]  residue
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic [PAGE_W-1:0] page;
  logic              auto_en;
  dma_seq_pkg::dir_e dir;
  logic              casc;
  logic              cnt_zero;

  dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .ld_page(ld_page), .ld_auto(ld_auto), .ld_dir(dma_seq_pkg::dir_e'(ld_dir)),
    .ld_casc(ld_casc), .step(xfer), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .page(page), .auto_en(auto_en), .dir(dir), .casc(casc), .cnt_zero(cnt_zero)
  );

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .grant(grant), .msk_set(msk_set),
    .msk_clr(msk_clr), .cnt_zero(cnt_zero), .auto_en(auto_en), .dir(dir),
    .casc(casc), .xfer(xfer), .tc(tc), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .casc_req(casc_req), .masked(masked)
  );

  dma_seq_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
                 .WORD_MODE(WORD_MODE)) u_addr (
    .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .cur_cnt(cur_cnt),
    .page(page), .mem_addr(mem_addr), .residue(residue)
  );
endmodule

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ld = 0, ld_auto = 0, ld_casc = 0, msk_set = 0, msk_clr = 0;
  logic        dreq = 0, grant = 0;
  logic [15:0] ld_addr = 0, ld_cnt = 0;
  logic [7:0]  ld_page = 0;
  logic [1:0]  ld_dir = 0;

  logic        b_xfer, b_tc, b_wr, b_rd, b_casc, b_mask;
  logic [23:0] b_addr;
  logic [17:0] b_res;
  logic        w_xfer, w_tc, w_wr, w_rd, w_casc, w_mask;
  logic [23:0] w_addr;
  logic [17:0] w_res;

  dma_xfer_seq #(.WORD_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .ld_page(ld_page), .ld_auto(ld_auto), .ld_dir(ld_dir), .ld_casc(ld_casc),
    .msk_set(msk_set), .msk_clr(msk_clr), .dreq(dreq), .grant(grant),
    .xfer(b_xfer), .tc(b_tc), .mem_wr(b_wr), .mem_rd(b_rd), .mem_addr(b_addr),
    .casc_req(b_casc), .masked(b_mask), .residue(b_res));

  dma_xfer_seq #(.WORD_MODE(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .ld_page(ld_page), .ld_auto(ld_auto), .ld_dir(ld_dir), .ld_casc(ld_casc),
    .msk_set(msk_set), .msk_clr(msk_clr), .dreq(dreq), .grant(grant),
    .xfer(w_xfer), .tc(w_tc), .mem_wr(w_wr), .mem_rd(w_rd), .mem_addr(w_addr),
    .casc_req(w_casc), .masked(w_mask), .residue(w_res));

  int n_chk = 0;
  int n_err = 0;
  int n_seen = 0;

  // bench model of the channel
  logic [15:0] m_addr, m_cnt, m_baddr, m_bcnt;
  logic [7:0]  m_page;
  logic        m_auto, m_casc, m_mask;
  logic [1:0]  m_dir;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] byte_addr(input logic [7:0] p, input logic [15:0] a);
    return (32'(p) << 16) | 32'(a);
  endfunction

  function automatic logic [31:0] word_addr(input logic [7:0] p, input logic [15:0] a);
    return (32'(p & 8'hFE) << 16) + 32'(a) * 2;
  endfunction

  function automatic logic [31:0] left_bytes(input logic [15:0] c, input bit words);
    return words ? (32'(c) + 1) * 2 : 32'(c) + 1;
  endfunction

  task automatic model_reset();
    m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0; m_page = 0;
    m_auto = 0; m_casc = 0; m_mask = 1; m_dir = 0;
  endtask

  // check outputs mid-cycle, then advance the model at the edge
  task automatic cycle();
    logic ex, et;
    #5;
    ex = dreq && grant && !m_mask && !m_casc;
    et = ex && (m_cnt == 0);
    cmp("R2 xfer", {31'b0, b_xfer}, {31'b0, ex});
    cmp("R2 xfer word", {31'b0, w_xfer}, {31'b0, ex});
    cmp("R4 tc", {31'b0, b_tc}, {31'b0, et});
    cmp("R7 strobes", {30'b0, b_wr, b_rd}, {30'b0, ex && m_dir == 2'b01, ex && m_dir == 2'b10});
    cmp("R7 strobes word", {30'b0, w_wr, w_rd}, {30'b0, ex && m_dir == 2'b01, ex && m_dir == 2'b10});
    cmp("R8 casc_req", {31'b0, b_casc}, {31'b0, dreq && !m_mask && m_casc});
    cmp("R6 masked", {30'b0, b_mask, w_mask}, {30'b0, m_mask, m_mask});
    cmp("R9 byte addr", 32'(b_addr), byte_addr(m_page, m_addr));
    cmp("R10 word addr", 32'(w_addr), word_addr(m_page, m_addr));
    cmp("R11 residue", 32'(b_res), left_bytes(m_cnt, 1'b0));
    cmp("R11 residue word", 32'(w_res), left_bytes(m_cnt, 1'b1));
    if (b_xfer) n_seen++;
    @(posedge clk);
    #1;
    if (msk_set || (et && !m_auto)) m_mask = 1;
    else if (msk_clr) m_mask = 0;
    if (ld) begin
      m_baddr = ld_addr; m_bcnt = ld_cnt; m_addr = ld_addr; m_cnt = ld_cnt;
      m_page = ld_page; m_auto = ld_auto; m_dir = ld_dir; m_casc = ld_casc;
    end else if (et && m_auto) begin
      m_addr = m_baddr; m_cnt = m_bcnt;
    end else if (ex) begin
      m_addr = m_addr + 1; m_cnt = m_cnt - 1;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    ld = 0; msk_set = 0; msk_clr = 0; dreq = 0; grant = 0;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                      input logic au, input logic [1:0] d, input logic cs);
    ld = 1; ld_addr = a; ld_cnt = c; ld_page = p; ld_auto = au; ld_dir = d; ld_casc = cs;
    cycle();
    ld = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1 masked", {31'b0, b_mask}, 32'd1);
    cmp("R1 idle", {28'b0, b_xfer, b_tc, b_wr, b_rd}, 32'd0);
    cmp("R1 residue", 32'(b_res), 32'd1);
    rst_n = 1;
    @(negedge clk);
    dreq = 1; grant = 1;
    cycle();               // masked: no transfer
    quiet();

    // R4/R6: three transfers with count 2, address wraps (R3)
    load(16'hFFFE, 16'd2, 8'h35, 1'b0, 2'b01, 1'b0);
    msk_clr = 1; cycle(); msk_clr = 0;
    n_seen = 0;
    dreq = 1; grant = 1;
    repeat (6) cycle();
    cmp("R4 transfer total", 32'(n_seen), 32'd3);
    quiet();

    // R5: auto-initialise keeps running
    load(16'h0100, 16'd1, 8'h12, 1'b1, 2'b10, 1'b0);
    msk_clr = 1; cycle(); msk_clr = 0;
    n_seen = 0;
    dreq = 1; grant = 1;
    repeat (7) cycle();
    cmp("R5 transfers continue", 32'(n_seen), 32'd7);
    quiet();

    // R11: largest count; R10 odd page
    load(16'h8001, 16'hFFFF, 8'h0B, 1'b0, 2'b00, 1'b0);
    cycle();
    dreq = 1; grant = 1; cycle(); cycle();
    // R12: load in the same cycle as a transfer
    ld = 1; ld_addr = 16'h4444; ld_cnt = 16'd0; ld_page = 8'h01; ld_auto = 0;
    ld_dir = 2'b01; ld_casc = 0;
    cycle(); ld = 0;
    // R6: tc collides with msk_clr, mask must win
    msk_clr = 1; cycle(); msk_clr = 0;
    cycle();
    quiet();
    // grant withheld (R2)
    msk_clr = 1; cycle(); msk_clr = 0;
    dreq = 1; grant = 0; cycle(); cycle();
    quiet();

    // R8: cascade passes request, no transfer
    load(16'h0010, 16'd3, 8'h20, 1'b0, 2'b01, 1'b1);
    dreq = 1; grant = 1; cycle(); cycle();
    quiet();

    // random traffic with short counts
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      quiet();
      if ($urandom_range(0, 15) == 0) begin
        ld = 1; ld_addr = 16'($urandom); ld_cnt = 16'($urandom_range(0, 5));
        ld_page = 8'($urandom); ld_auto = 1'($urandom); ld_dir = 2'($urandom);
        ld_casc = ($urandom_range(0, 7) == 0);
      end
      msk_set = ($urandom_range(0, 31) == 0);
      msk_clr = ($urandom_range(0, 3) == 0);
      dreq = ($urandom_range(0, 3) != 0);
      grant = ($urandom_range(0, 3) != 0);
      cycle();
    end
    quiet();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule